// File: doc/BRIEF.md
# Dual-Pipe Instruction Pairing Issue Logic

This block sits between an in-order instruction queue and two integer execution pipes of unequal ability. The U pipe accepts any instruction; the V pipe accepts only simple ones. Each cycle the block looks at the two oldest queue entries and decides whether to send one instruction or two. The oldest entry always goes to U. The entry behind it goes to V in the same cycle only when all of these hold:
- both entries are simple;
- the younger entry neither reads nor rewrites the older one's destination register;
- the V pipe can take a new instruction.

Any other case collapses the cycle to single issue on U. The younger entry then stays at the head of the queue and is looked at again in the next cycle.

The decision leaves the block in two ways:
- **Pop count.** A combinational pop count of 0, 1 or 2 tells the queue how many entries leave in the current cycle.
- **Issue registers.** One issue register per pipe carries the chosen instruction word and its valid bit, starting from the next clock edge.

A stall from U freezes the whole issue stage, because V may never run ahead of U.

Top module: `dual_pipe_issue`

## Requirements
- R1: While `rst_n` is low, `pop_cnt` is 0. After reset, `u_vld` and `v_vld` are both 0 until an issue takes place.
- R2: Dual issue happens when all of the following hold in the same cycle:
  - `q0_vld` and `q1_vld` are both 1 and `u_stall` and `v_busy` are both 0;
  - neither entry is complex;
  - the pair has no register hazard.

  In that case `pop_cnt` is 2, and from the next edge `u_word` equals the `q0_word` and `v_word` equals the `q1_word` that were presented. Word layout with REG_W=5 and PAY_W=16, MSB first:
  - bit 34: complex class;
  - bit 33: destination valid; bits 32:28: destination;
  - bit 27: source A valid; bits 26:22: source A;
  - bit 21: source B valid; bits 20:16: source B;
  - bits 15:0: opaque payload.
- R3: A read-after-write hazard exists when a valid source of the younger entry equals the valid destination of the older entry. The cycle is then single issue: `pop_cnt` is 1, `u_word` takes `q0_word` and `v_vld` is 0 on the next cycle.
- R4: A write-after-write hazard exists when both entries have valid, equal destinations. It also forces single issue, with the same outputs as R3.
- R5: If either head entry has the complex bit (bit 34) set, the cycle issues at most one instruction, on U.
- R6: If `q0_vld` is 1 and `q1_vld` is 0, the head entry issues alone on U (`pop_cnt` 1). If `q0_vld` is 0, `pop_cnt` is 0 and both valid outputs are 0 on the next cycle, whatever `q1_vld` holds.
- R7: While `u_stall` is 1, `pop_cnt` is 0. On the following cycle `u_vld`, `u_word`, `v_vld` and `v_word` keep their values.
- R8: While `v_busy` is 1, `pop_cnt` is never 2, and `v_vld` is 0 on the next cycle unless U is stalled.
- R9: Order is preserved. `pop_cnt` only takes the values 0, 1 and 2. `v_vld` is never 1 while `u_vld` is 0, and V only ever carries the entry directly behind the one issued to U in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q0_vld | input | 1 | Oldest queue entry is valid |
| q0_word | input | INSTR_W | Oldest queue entry |
| q1_vld | input | 1 | Second-oldest queue entry is valid |
| q1_word | input | INSTR_W | Second-oldest queue entry |
| u_stall | input | 1 | U pipe cannot accept; freezes the issue stage |
| v_busy | input | 1 | V pipe cannot accept a new instruction |
| pop_cnt | output | 2 | Entries removed from the queue this cycle |
| u_vld | output | 1 | Instruction presented to U is valid |
| u_word | output | INSTR_W | Instruction presented to U |
| v_vld | output | 1 | Instruction presented to V is valid |
| v_word | output | INSTR_W | Instruction presented to V |

## Verification
A behavioural model holds the queue as a list of instructions. It drives the block with a register index space of only eight values, so that read-after-write and write-after-write collisions occur often, and with complex entries mixed in. This tells apart a correct hazard check from one that ignores either hazard kind, ignores the source or destination valid bits, or swaps the roles of the two entries.

Random stalls on U, random V back-pressure, drain phases that leave zero or one entries, and cycles with a gap at the head show whether pops, holds and collapses are decided in the right priority. Every cycle is labelled with the rule that governs it, and each rule must be seen at least once.

// File: rtl/dual_pipe_issue_pkg.sv
package dual_pipe_issue_pkg;

  // Number of instructions leaving the queue in one cycle
  typedef enum logic [1:0] {
    ISSUE_NONE = 2'd0,
    ISSUE_ONE  = 2'd1,
    ISSUE_TWO  = 2'd2
  } issue_mode_e;

  // Header = class bit, destination and two sources, each with a valid bit
  function automatic int hdr_width(input int reg_w);
    return 3 * reg_w + 4;
  endfunction

  function automatic int word_width(input int reg_w, input int pay_w);
    return hdr_width(reg_w) + pay_w;
  endfunction

endpackage

// File: rtl/pair_hazard.sv
// Register dependency check between the older (U) and younger (V) candidate
module pair_hazard #(
  parameter int REG_W = 5
) (
  input  logic             older_dst_vld,
  input  logic [REG_W-1:0] older_dst,
  // younger fields, MSB first: dst_vld, dst, sa_vld, sa, sb_vld, sb
  input  logic [3*REG_W+2:0] younger_regs,
  output logic             raw_hit,
  output logic             waw_hit
);

  localparam int SB_LO  = 0;
  localparam int SB_V   = REG_W;
  localparam int SA_LO  = REG_W + 1;
  localparam int SA_V   = 2 * REG_W + 1;
  localparam int DST_LO = 2 * REG_W + 2;
  localparam int DST_V  = 3 * REG_W + 2;

  function automatic logic reg_collide(input logic a_vld, input logic [REG_W-1:0] a,
                                       input logic b_vld, input logic [REG_W-1:0] b);
    return a_vld && b_vld && (a == b);
  endfunction

  logic             y_sa_vld, y_sb_vld, y_dst_vld;
  logic [REG_W-1:0] y_sa, y_sb, y_dst;
  logic             sa_hit, sb_hit;

  assign y_sb      = younger_regs[SB_LO +: REG_W];
  assign y_sb_vld  = younger_regs[SB_V];
  assign y_sa      = younger_regs[SA_LO +: REG_W];
  assign y_sa_vld  = younger_regs[SA_V];
  assign y_dst     = younger_regs[DST_LO +: REG_W];
  assign y_dst_vld = younger_regs[DST_V];

  assign sa_hit  = reg_collide(y_sa_vld, y_sa, older_dst_vld, older_dst);
  assign sb_hit  = reg_collide(y_sb_vld, y_sb, older_dst_vld, older_dst);
  assign raw_hit = sa_hit | sb_hit;
  assign waw_hit = reg_collide(y_dst_vld, y_dst, older_dst_vld, older_dst);

endmodule

// File: rtl/pair_select.sv
// Decides single, dual or no issue for the current cycle
module pair_select
  import dual_pipe_issue_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       q0_vld,
  input  logic       q1_vld,
  input  logic       q0_cpx,
  input  logic       q1_cpx,
  input  logic       raw_hit,
  input  logic       waw_hit,
  input  logic       u_stall,
  input  logic       v_busy,
  output logic [1:0] pop_cnt,
  output logic       load_u,
  output logic       load_v
);

  issue_mode_e mode;
  logic cls_block;   // a complex instruction cannot pair
  logic dep_block;   // register hazard between the pair
  logic v_block;     // V cannot take an instruction
  logic pair_ok;

  assign cls_block = q0_cpx | q1_cpx;
  assign dep_block = raw_hit | waw_hit;
  assign v_block   = v_busy;
  assign pair_ok   = q0_vld & q1_vld & ~cls_block & ~dep_block & ~v_block;

  always_comb begin
    if (!rst_n || u_stall || !q0_vld) mode = ISSUE_NONE;
    else if (pair_ok)                 mode = ISSUE_TWO;
    else                              mode = ISSUE_ONE;
  end

  assign pop_cnt = mode;
  assign load_u  = (mode != ISSUE_NONE);
  assign load_v  = (mode == ISSUE_TWO);

  // R7
  stall_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    u_stall |-> (pop_cnt == 2'd0));

  // R5
  cls_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q0_cpx || q1_cpx) |-> (pop_cnt != 2'd2));

  // R3 R4
  hazard_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_hit || waw_hit) |-> (pop_cnt != 2'd2));

  // R8
  vbusy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v_busy |-> (pop_cnt != 2'd2));

  // R6
  empty_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !q0_vld |-> (pop_cnt == 2'd0));

  // R9
  pop_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_cnt != 2'd3));

endmodule

// File: rtl/issue_slot.sv
// Issue register feeding one pipe; frozen while U stalls
module issue_slot #(
  parameter int W = 35
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic         load_vld,
  input  logic [W-1:0] load_word,
  output logic         vld_q,
  output logic [W-1:0] word_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      word_q <= '0;
    end else if (!hold) begin
      vld_q  <= load_vld;
      word_q <= load_vld ? load_word : '0;
    end
  end

endmodule

// File: rtl/dual_pipe_issue.sv
module dual_pipe_issue
  import dual_pipe_issue_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter int PAY_W   = 16,
  parameter int INSTR_W = word_width(REG_W, PAY_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               q0_vld,
  input  logic [INSTR_W-1:0] q0_word,
  input  logic               q1_vld,
  input  logic [INSTR_W-1:0] q1_word,
  input  logic               u_stall,
  input  logic               v_busy,
  output logic [1:0]         pop_cnt,
  output logic               u_vld,
  output logic [INSTR_W-1:0] u_word,
  output logic               v_vld,
  output logic [INSTR_W-1:0] v_word
);

  localparam int NPIPE  = 2;
  localparam int CLS_B  = INSTR_W - 1;
  localparam int DST_V  = INSTR_W - 2;
  localparam int DST_LO = INSTR_W - 2 - REG_W;
  localparam int REGS_W = 3 * REG_W + 3;

  // named internal events
  logic raw_hit, waw_hit;
  logic load_u, load_v;
  logic q0_cpx, q1_cpx;

  assign q0_cpx = q0_word[CLS_B];
  assign q1_cpx = q1_word[CLS_B];

  pair_hazard #(.REG_W(REG_W)) u_hazard (
    .older_dst_vld (q0_word[DST_V]),
    .older_dst     (q0_word[DST_LO +: REG_W]),
    .younger_regs  (q1_word[PAY_W +: REGS_W]),
    .raw_hit       (raw_hit),
    .waw_hit       (waw_hit)
  );

  pair_select u_select (
    .clk     (clk),
    .rst_n   (rst_n),
    .q0_vld  (q0_vld),
    .q1_vld  (q1_vld),
    .q0_cpx  (q0_cpx),
    .q1_cpx  (q1_cpx),
    .raw_hit (raw_hit),
    .waw_hit (waw_hit),
    .u_stall (u_stall),
    .v_busy  (v_busy),
    .pop_cnt (pop_cnt),
    .load_u  (load_u),
    .load_v  (load_v)
  );

  logic               slot_load [NPIPE];
  logic [INSTR_W-1:0] slot_in   [NPIPE];
  logic               slot_vld  [NPIPE];
  logic [INSTR_W-1:0] slot_word [NPIPE];

  // slot 0 is U, slot 1 is V: U always gets the older entry
  assign slot_load[0] = load_u;
  assign slot_in[0]   = q0_word;
  assign slot_load[1] = load_v;
  assign slot_in[1]   = q1_word;

  for (genvar p = 0; p < NPIPE; p++) begin : g_slot
    issue_slot #(.W(INSTR_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold      (u_stall),
      .load_vld  (slot_load[p]),
      .load_word (slot_in[p]),
      .vld_q     (slot_vld[p]),
      .word_q    (slot_word[p])
    );
  end

  assign u_vld  = slot_vld[0];
  assign u_word = slot_word[0];
  assign v_vld  = slot_vld[1];
  assign v_word = slot_word[1];

  // R2
  dual_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q0_vld && q1_vld && !q0_cpx && !q1_cpx && !raw_hit && !waw_hit && !u_stall && !v_busy)
      |-> (pop_cnt == 2'd2));

  // R2
  dual_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_cnt == 2'd2) |=> (v_vld && v_word == $past(q1_word) && u_word == $past(q0_word)));

  // R9
  order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v_vld |-> u_vld);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    u_stall |=> ($stable(u_vld) && $stable(u_word) && $stable(v_vld) && $stable(v_word)));

  // R8
  vbusy_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v_busy && !u_stall) |=> !v_vld);

  // R1
  always_comb begin
    if (!rst_n) begin
      reset_quiet_chk: assert (pop_cnt == 2'd0);
    end
  end

endmodule

// File: tb/dual_pipe_issue_tb.sv
module dual_pipe_issue_tb;
  localparam int REG_W = 5;
  localparam int PAY_W = 16;
  localparam int IW    = 3 * REG_W + 4 + PAY_W;
  localparam int NCYC  = 4000;

  typedef struct {
    logic             cpx;
    logic             dv;
    logic [REG_W-1:0] dst;
    logic             av;
    logic [REG_W-1:0] sa;
    logic             bv;
    logic [REG_W-1:0] sb;
    logic [PAY_W-1:0] pay;
  } ins_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic q0_vld = 1'b0, q1_vld = 1'b0;
  logic [IW-1:0] q0_word = '0, q1_word = '0;
  logic u_stall = 1'b0, v_busy = 1'b0;
  logic [1:0] pop_cnt;
  logic u_vld, v_vld;
  logic [IW-1:0] u_word, v_word;

  always #10 clk = ~clk;

  dual_pipe_issue u_dut (
    .clk(clk), .rst_n(rst_n),
    .q0_vld(q0_vld), .q0_word(q0_word), .q1_vld(q1_vld), .q1_word(q1_word),
    .u_stall(u_stall), .v_busy(v_busy), .pop_cnt(pop_cnt),
    .u_vld(u_vld), .u_word(u_word), .v_vld(v_vld), .v_word(v_word)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  int seen[string];

  ins_t q[$];
  int   pay_seq = 0;

  function automatic logic [IW-1:0] pack(input ins_t i);
    return {i.cpx, i.dv, i.dst, i.av, i.sa, i.bv, i.sb, i.pay};
  endfunction

  function automatic ins_t fresh();
    ins_t i;
    i.cpx = ($urandom_range(99) < 20);
    i.dv  = ($urandom_range(99) < 85);
    i.dst = REG_W'($urandom_range(7));
    i.av  = ($urandom_range(99) < 70);
    i.sa  = REG_W'($urandom_range(7));
    i.bv  = ($urandom_range(99) < 50);
    i.sb  = REG_W'($urandom_range(7));
    i.pay = PAY_W'(pay_seq);
    pay_seq++;
    return i;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected state of the issue registers
  bit            e_uv = 0, e_vv = 0;
  logic [IW-1:0] e_uw = '0, e_vw = '0;

  initial begin
    #(20 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state, with valid entries presented
    q0_vld = 1; q1_vld = 1;
    repeat (3) @(negedge clk);
    check(pop_cnt == 0, "R1", "pop_cnt in reset", 64'(pop_cnt), 0);
    check(!u_vld && !v_vld, "R1", "valids in reset", {u_vld, v_vld}, 0);
    q0_vld = 0; q1_vld = 0;
    rst_n = 1;
    @(negedge clk);
    check(!u_vld && !v_vld, "R1", "valids after reset", {u_vld, v_vld}, 0);

    for (int c = 0; c < NCYC; c++) begin
      bit st, vb, gap, a_ok, b_ok, raw, waw;
      int ep;
      string why;
      ins_t a, b;
      bit drain = ((c % 300) >= 270);
      if (!drain) begin
        int n = $urandom_range(2);
        for (int k = 0; k < n; k++) if (q.size() < 6) q.push_back(fresh());
      end
      st  = ($urandom_range(99) < 15);
      vb  = ($urandom_range(99) < 15);
      gap = ($urandom_range(99) < 8);
      a_ok = (q.size() > 0) && !gap;
      b_ok = (q.size() > 1);
      if (q.size() > 0) a = q[0];
      if (q.size() > 1) b = q[1];
      u_stall = st; v_busy = vb;
      q0_vld = a_ok; q1_vld = b_ok;
      q0_word = (q.size() > 0) ? pack(a) : '0;
      q1_word = (q.size() > 1) ? pack(b) : '0;

      raw = 0; waw = 0;
      if (b_ok && q.size() > 1) begin
        raw = (b.av && a.dv && b.sa == a.dst) || (b.bv && a.dv && b.sb == a.dst);
        waw = b.dv && a.dv && b.dst == a.dst;
      end
      if (st)                     begin ep = 0; why = "R7"; end
      else if (!a_ok)             begin ep = 0; why = "R6"; end
      else if (!b_ok)             begin ep = 1; why = "R6"; end
      else if (a.cpx || b.cpx)    begin ep = 1; why = "R5"; end
      else if (raw)               begin ep = 1; why = "R3"; end
      else if (waw)               begin ep = 1; why = "R4"; end
      else if (vb)                begin ep = 1; why = "R8"; end
      else                        begin ep = 2; why = "R2"; end
      seen[why] = 1;

      #2;
      check(pop_cnt == ep[1:0], why, "pop_cnt", 64'(pop_cnt), 64'(ep));
      @(posedge clk);
      if (!st) begin
        e_uv = (ep >= 1); e_uw = (ep >= 1) ? pack(a) : '0;
        e_vv = (ep == 2); e_vw = (ep == 2) ? pack(b) : '0;
      end
      for (int k = 0; k < ep; k++) void'(q.pop_front());
      @(negedge clk);
      check(u_vld == e_uv, why, "u_vld", 64'(u_vld), 64'(e_uv));
      check(v_vld == e_vv, why, "v_vld", 64'(v_vld), 64'(e_vv));
      if (e_uv) check(u_word == e_uw, why, "u_word", 64'(u_word), 64'(e_uw));
      if (e_vv) check(v_word == e_vw, why, "v_word", 64'(v_word), 64'(e_vw));
      // R9: V never valid alone
      check(!(v_vld && !u_vld), "R9", "v without u", {u_vld, v_vld}, 2'b11);
    end

    // every rule must have governed at least one cycle
    check(seen.exists("R2"), "R2", "dual issue exercised", 0, 1);
    check(seen.exists("R3"), "R3", "raw exercised", 0, 1);
    check(seen.exists("R4"), "R4", "waw exercised", 0, 1);
    check(seen.exists("R5"), "R5", "complex exercised", 0, 1);
    check(seen.exists("R6"), "R6", "short queue exercised", 0, 1);
    check(seen.exists("R7"), "R7", "stall exercised", 0, 1);
    check(seen.exists("R8"), "R8", "v busy exercised", 0, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule